// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block sits between a host bus and an embedded keyboard/mouse microcontroller. The host side sees three things. It can write into a single input buffer, either as data or as a command. It can read an output buffer. It can read a status byte. The host picks between the two addresses with one address line, `host_sa2`. The controller side can take the byte out of the input buffer and learn whether that byte was a command or data. It can also place a byte in the output buffer and write a small port register that drives the keyboard interrupt, the mouse interrupt and the gate-A20 line.

The two interrupt lines run in one of two modes. While the enable-flags latch is clear, each interrupt is a plain copy of its port bit. Once the controller pulses the enable-flags strobe, the latch stays set until reset. In that mode the keyboard interrupt shows the output-buffer-full flag, and the mouse interrupt shows the inverse of the input-buffer-full flag. In both cases the port bit acts as a mask. The enable-flags latch also decides whether a host read of the data address empties the output buffer by itself.

All state lives in registers that are cleared by a synchronous active-high reset. All outputs are combinational functions of that state and, for `host_rdata`, of the current address line.

Top module: `kbc_host_if`

## Requirements
- R1: A host write with `host_sa2`=0 stores `host_wdata` in the input buffer. From the next cycle, IBF is 1 and the command flag is 0.
- R2: A host write with `host_sa2`=1 stores `host_wdata` in the same input buffer. From the next cycle, IBF is 1 and the command flag is 1.
- R3: With `host_sa2`=1, `host_rdata` is the status byte: bit 0 is OBF, bit 1 is IBF, bit 3 is the command flag, and every other bit is 0. With `host_sa2`=0, `host_rdata` is the output buffer.
- R4: A controller read pulse (`cpu_ibuf_rd`) clears IBF on the next cycle. If a host write happens in the same cycle, IBF ends up 1.
- R5: A controller write (`cpu_obuf_wr`) loads the output buffer and sets OBF. This set wins over any clear that happens in the same cycle.
- R6: While enable-flags is set, a host read with `host_sa2`=0 clears OBF on the next cycle. The keyboard interrupt therefore drops too.
- R7: While enable-flags is clear, a host read of the data address leaves OBF unchanged. The `cpu_obf_clr` pulse clears OBF in either mode.
- R8: While enable-flags is set, `kbd_irq` equals OBF AND port bit 1.
- R9: While enable-flags is set, `mouse_irq` equals (NOT IBF) AND port bit 2.
- R10: While enable-flags is clear, `kbd_irq` equals port bit 1 and `mouse_irq` equals port bit 2.
- R11: A `cpu_port_wr` pulse loads the 3-bit port from `cpu_port_wdata`: bit 0 is gate-A20, bit 1 is the keyboard interrupt control, bit 2 is the mouse interrupt control. `gate_a20` equals port bit 0.
- R12: A `cpu_en_flags` pulse sets enable-flags from the next cycle, and it stays set until reset. Reset clears the buffers, all flags, the port and enable-flags, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sa2 | input | 1 | Address select: 1 = command/status, 0 = data |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Status byte or output buffer |
| cpu_ibuf_rd | input | 1 | Controller takes the input buffer |
| cpu_ibuf_data | output | DATA_W | Input buffer contents |
| cpu_cmd_flag | output | 1 | 1 when the last host write was a command |
| cpu_obuf_wr | input | 1 | Controller write to the output buffer |
| cpu_obuf_wdata | input | DATA_W | Output buffer byte |
| cpu_obf_clr | input | 1 | Software clear of OBF |
| cpu_port_wr | input | 1 | Port register write strobe |
| cpu_port_wdata | input | 3 | Port value {mouse ctl, kbd ctl, a20} |
| cpu_en_flags | input | 1 | Sets the enable-flags latch |
| kbd_irq | output | 1 | Keyboard interrupt |
| mouse_irq | output | 1 | Mouse interrupt |
| gate_a20 | output | 1 | Gate-A20 output |

## Verification
The bench aims at same-cycle collisions. One is a host write meeting a controller read; a design that lets the clear win would drop a freshly written byte. Another is an output-buffer write meeting a host data read; getting that wrong loses a keyboard interrupt. A third group covers mode changes. A bench for this block must show that a host read leaves OBF alone while enable-flags is clear, and that the mouse interrupt rises when IBF empties, not when it fills. A design with the inversion missing, or the masking swapped between the two interrupt lines, fails those checks. Long random runs in both modes compare every output against a model kept in the bench each cycle.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  // status byte bit positions seen by the host
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CD  = 3;
  // port register bit positions
  localparam int PORT_W   = 3;
  localparam int PB_A20   = 0;
  localparam int PB_KBD   = 1;
  localparam int PB_MOUSE = 2;

  // interrupt selection: gated by a flag when enabled, else direct port bit
  function automatic logic irq_select(logic en_flags, logic port_bit, logic flag);
    return en_flags ? (port_bit & flag) : port_bit;
  endfunction
endpackage

// File: rtl/kbc_ibuf.sv
module kbc_ibuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_cmd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] buf_data,
  output logic              ibf,
  output logic              cmd_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      ibf      <= 1'b0;
      cmd_flag <= 1'b0;
    end else if (host_wr) begin
      buf_data <= host_wdata;
      cmd_flag <= host_cmd;
      ibf      <= 1'b1;
    end else if (cpu_rd) begin
      ibf      <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              host_take,
  input  logic              sw_clr,
  output logic [DATA_W-1:0] buf_data,
  output logic              obf
);
  logic clr_evt;
  assign clr_evt = host_take | sw_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      obf      <= 1'b0;
    end else if (cpu_wr) begin
      buf_data <= cpu_wdata;
      obf      <= 1'b1;
    end else if (clr_evt) begin
      obf      <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_irq_ctl.sv
module kbc_irq_ctl
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_strobe,
  input  logic              port_wr,
  input  logic [PORT_W-1:0] port_wdata,
  input  logic              ibf,
  input  logic              obf,
  output logic              en_flags,
  output logic              port_kbd,
  output logic              port_mouse,
  output logic              kbd_irq,
  output logic              mouse_irq,
  output logic              gate_a20
);
  logic [PORT_W-1:0] port_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_flags <= 1'b0;
      port_q   <= '0;
    end else begin
      if (en_strobe) en_flags <= 1'b1;
      if (port_wr)   port_q   <= port_wdata;
    end
  end

  assign port_kbd   = port_q[PB_KBD];
  assign port_mouse = port_q[PB_MOUSE];
  assign gate_a20   = port_q[PB_A20];
  assign kbd_irq    = irq_select(en_flags, port_kbd, obf);
  assign mouse_irq  = irq_select(en_flags, port_mouse, ~ibf);
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sa2,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cpu_ibuf_rd,
  output logic [DATA_W-1:0] cpu_ibuf_data,
  output logic              cpu_cmd_flag,
  input  logic              cpu_obuf_wr,
  input  logic [DATA_W-1:0] cpu_obuf_wdata,
  input  logic              cpu_obf_clr,
  input  logic              cpu_port_wr,
  input  logic [PORT_W-1:0] cpu_port_wdata,
  input  logic              cpu_en_flags,
  output logic              kbd_irq,
  output logic              mouse_irq,
  output logic              gate_a20
);
  // named internal events, also observed by the bound checker
  logic              ibf_q, obf_q, en_q, p24_q, p25_q;
  logic              host_data_rd, host_take;
  logic [DATA_W-1:0] obuf_q, status_byte;

  assign host_data_rd = host_rd & ~host_sa2;
  assign host_take    = host_data_rd & en_q;

  kbc_ibuf #(.DATA_W(DATA_W)) u_ibuf (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_cmd(host_sa2),
    .host_wdata(host_wdata), .cpu_rd(cpu_ibuf_rd),
    .buf_data(cpu_ibuf_data), .ibf(ibf_q), .cmd_flag(cpu_cmd_flag)
  );

  kbc_obuf #(.DATA_W(DATA_W)) u_obuf (
    .clk(clk), .rst(rst), .cpu_wr(cpu_obuf_wr), .cpu_wdata(cpu_obuf_wdata),
    .host_take(host_take), .sw_clr(cpu_obf_clr),
    .buf_data(obuf_q), .obf(obf_q)
  );

  kbc_irq_ctl u_irq (
    .clk(clk), .rst(rst), .en_strobe(cpu_en_flags),
    .port_wr(cpu_port_wr), .port_wdata(cpu_port_wdata),
    .ibf(ibf_q), .obf(obf_q), .en_flags(en_q),
    .port_kbd(p24_q), .port_mouse(p25_q),
    .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .gate_a20(gate_a20)
  );

  always_comb begin
    status_byte         = '0;
    status_byte[ST_OBF] = obf_q;
    status_byte[ST_IBF] = ibf_q;
    status_byte[ST_CD]  = cpu_cmd_flag;
  end

  assign host_rdata = host_sa2 ? status_byte : obuf_q;
endmodule

// File: rtl/kbc_host_if_chk.sv
module kbc_host_if_chk
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic              host_sa2,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              cpu_ibuf_rd,
  input logic [DATA_W-1:0] cpu_ibuf_data,
  input logic              cpu_cmd_flag,
  input logic              cpu_obuf_wr,
  input logic              cpu_obf_clr,
  input logic              cpu_port_wr,
  input logic [PORT_W-1:0] cpu_port_wdata,
  input logic              cpu_en_flags,
  input logic              kbd_irq,
  input logic              mouse_irq,
  input logic              gate_a20,
  input logic              ibf_q,
  input logic              obf_q,
  input logic              en_q,
  input logic              p24_q,
  input logic              p25_q
);
  assert_data_write_R1: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_sa2) |=> (ibf_q && !cpu_cmd_flag && cpu_ibuf_data == $past(host_wdata)));

  assert_cmd_write_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_sa2) |=> (ibf_q && cpu_cmd_flag));

  assert_ibuf_take_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ibuf_rd && !host_wr) |=> !ibf_q);

  assert_obuf_set_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_obuf_wr |=> obf_q);

  assert_host_take_R6: assert property (@(posedge clk) disable iff (rst)
    (en_q && host_rd && !host_sa2 && !cpu_obuf_wr) |=> !obf_q);

  assert_obf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_q && obf_q && !cpu_obf_clr) |=> obf_q);

  assert_kbd_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (en_q && host_sa2) |-> (kbd_irq == (p24_q && host_rdata[ST_OBF])));

  assert_mouse_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q && host_sa2) |-> (mouse_irq == (p25_q && !host_rdata[ST_IBF])));

  assert_direct_irq_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_port_wr && !en_q && !cpu_en_flags) |=>
      (kbd_irq == $past(cpu_port_wdata[PB_KBD]) && mouse_irq == $past(cpu_port_wdata[PB_MOUSE])));

  assert_a20_port_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_port_wr |=> (gate_a20 == $past(cpu_port_wdata[PB_A20])));

  assert_en_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (en_q || cpu_en_flags) |=> en_q);
endmodule

bind kbc_host_if kbc_host_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_sa2(host_sa2),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .cpu_ibuf_rd(cpu_ibuf_rd),
  .cpu_ibuf_data(cpu_ibuf_data), .cpu_cmd_flag(cpu_cmd_flag), .cpu_obuf_wr(cpu_obuf_wr),
  .cpu_obf_clr(cpu_obf_clr), .cpu_port_wr(cpu_port_wr), .cpu_port_wdata(cpu_port_wdata),
  .cpu_en_flags(cpu_en_flags), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
  .gate_a20(gate_a20), .ibf_q(ibf_q), .obf_q(obf_q), .en_q(en_q),
  .p24_q(p24_q), .p25_q(p25_q)
);

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic host_wr = 0, host_rd = 0, host_sa2 = 0;
  logic [W-1:0] host_wdata = '0, host_rdata, cpu_ibuf_data, cpu_obuf_wdata = '0;
  logic cpu_ibuf_rd = 0, cpu_cmd_flag, cpu_obuf_wr = 0, cpu_obf_clr = 0;
  logic cpu_port_wr = 0, cpu_en_flags = 0;
  logic [2:0] cpu_port_wdata = '0;
  logic kbd_irq, mouse_irq, gate_a20;

  always #4 clk = ~clk;

  kbc_host_if #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_sa2(host_sa2),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cpu_ibuf_rd(cpu_ibuf_rd),
    .cpu_ibuf_data(cpu_ibuf_data), .cpu_cmd_flag(cpu_cmd_flag), .cpu_obuf_wr(cpu_obuf_wr),
    .cpu_obuf_wdata(cpu_obuf_wdata), .cpu_obf_clr(cpu_obf_clr), .cpu_port_wr(cpu_port_wr),
    .cpu_port_wdata(cpu_port_wdata), .cpu_en_flags(cpu_en_flags), .kbd_irq(kbd_irq),
    .mouse_irq(mouse_irq), .gate_a20(gate_a20)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_ibuf, m_obuf;
  logic m_ibf, m_cd, m_obf, m_en;
  logic [2:0] m_port;

  function automatic logic [W-1:0] st_exp(logic obf, logic ibf, logic cd);
    logic [W-1:0] s = '0;
    s = s | {4'b0, cd, 1'b0, ibf, obf};
    return s;
  endfunction

  function automatic logic kirq_exp(logic en, logic [2:0] p, logic obf);
    if (en) return p[1] && obf;
    return p[1];
  endfunction

  function automatic logic mirq_exp(logic en, logic [2:0] p, logic ibf);
    if (en) return p[2] && !ibf;
    return p[2];
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ibuf = '0; m_obuf = '0; m_ibf = 0; m_cd = 0; m_obf = 0; m_en = 0; m_port = '0;
  endtask

  task automatic model_step();
    logic next_en;
    next_en = m_en | cpu_en_flags;
    if (host_wr) begin m_ibuf = host_wdata; m_cd = host_sa2; m_ibf = 1; end
    else if (cpu_ibuf_rd) m_ibf = 0;
    if (cpu_obuf_wr) begin m_obuf = cpu_obuf_wdata; m_obf = 1; end
    else if ((host_rd && !host_sa2 && m_en) || cpu_obf_clr) m_obf = 0;
    if (cpu_port_wr) m_port = cpu_port_wdata;
    m_en = next_en;
  endtask

  task automatic check_all();
    chk("R1 ibuf data", cpu_ibuf_data, m_ibuf);
    chk("R2 cmd flag", {7'b0, cpu_cmd_flag}, {7'b0, m_cd});
    if (host_sa2) chk("R3 status", host_rdata, st_exp(m_obf, m_ibf, m_cd));
    else          chk("R5 obuf", host_rdata, m_obuf);
    chk(m_en ? "R8 kbd gated" : "R10 kbd direct", {7'b0, kbd_irq}, {7'b0, kirq_exp(m_en, m_port, m_obf)});
    chk(m_en ? "R9 mouse gated" : "R10 mouse direct", {7'b0, mouse_irq}, {7'b0, mirq_exp(m_en, m_port, m_ibf)});
    chk("R11 a20", {7'b0, gate_a20}, {7'b0, m_port[0]});
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; cpu_ibuf_rd = 0; cpu_obuf_wr = 0;
    cpu_obf_clr = 0; cpu_port_wr = 0; cpu_en_flags = 0;
  endtask

  // one clock: inputs already driven at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    idle(); rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic rand_cycles(int n, bit allow_en);
    for (int i = 0; i < n; i++) begin
      host_wr        = ($urandom % 4) == 0;
      host_rd        = ($urandom % 3) == 0;
      host_sa2       = $urandom % 2;
      host_wdata     = W'($urandom);
      cpu_ibuf_rd    = ($urandom % 3) == 0;
      cpu_obuf_wr    = ($urandom % 4) == 0;
      cpu_obuf_wdata = W'($urandom);
      cpu_obf_clr    = ($urandom % 10) == 0;
      cpu_port_wr    = ($urandom % 8) == 0;
      cpu_port_wdata = 3'($urandom);
      cpu_en_flags   = allow_en && (($urandom % 200) == 0);
      cyc();
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    @(negedge clk);
    do_reset();
    // R12 reset state
    host_sa2 = 1; #1;
    chk("R12 reset status", host_rdata, 8'h00);
    chk("R12 reset irqs", {5'b0, gate_a20, mouse_irq, kbd_irq}, 8'h00);

    // R1 data write
    host_wr = 1; host_sa2 = 0; host_wdata = 8'h5A; cyc(); idle();
    host_sa2 = 1; #1;
    chk("R1 data byte", cpu_ibuf_data, 8'h5A);
    chk("R1 status after data", host_rdata, 8'h02);
    // R2 command write
    host_wr = 1; host_sa2 = 1; host_wdata = 8'hD1; cyc(); idle(); #1;
    chk("R2 status after cmd", host_rdata, 8'h0A);
    chk("R2 cmd byte", cpu_ibuf_data, 8'hD1);
    // R4 controller take, then collision
    cpu_ibuf_rd = 1; cyc(); idle(); #1;
    chk("R4 ibf cleared", host_rdata, 8'h08);
    cpu_ibuf_rd = 1; host_wr = 1; host_sa2 = 0; host_wdata = 8'h11; cyc(); idle();
    host_sa2 = 1; #1;
    chk("R4 write wins", host_rdata, 8'h02);
    cpu_ibuf_rd = 1; cyc(); idle();

    // R5 output write; R7 host read without enable leaves OBF
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h33; cyc(); idle();
    host_sa2 = 0; #1;
    chk("R5 obuf byte", host_rdata, 8'h33);
    host_rd = 1; host_sa2 = 0; cyc(); idle();
    host_sa2 = 1; #1;
    chk("R7 obf kept", host_rdata, 8'h01);
    cpu_obf_clr = 1; cyc(); idle(); #1;
    chk("R7 sw clear", host_rdata, 8'h00);

    // R10/R11 direct port control
    cpu_port_wr = 1; cpu_port_wdata = 3'b111; cyc(); idle(); #1;
    chk("R10 R11 direct all high", {5'b0, gate_a20, mouse_irq, kbd_irq}, 8'h07);
    // R12 enable; R8 kbd gated by OBF=0; R9 mouse high while IBF empty
    cpu_en_flags = 1; cyc(); idle(); #1;
    chk("R8 kbd gated low", {7'b0, kbd_irq}, 8'h00);
    chk("R9 mouse empty high", {7'b0, mouse_irq}, 8'h01);
    host_wr = 1; host_sa2 = 0; host_wdata = 8'h77; cyc(); idle(); #1;
    chk("R9 mouse low when full", {7'b0, mouse_irq}, 8'h00);
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'hA5; cyc(); idle(); #1;
    chk("R8 kbd follows obf", {7'b0, kbd_irq}, 8'h01);
    host_rd = 1; host_sa2 = 0; cyc(); idle(); #1;
    chk("R6 host read clears irq", {7'b0, kbd_irq}, 8'h00);
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h3C; host_rd = 1; host_sa2 = 0; cyc(); idle(); #1;
    chk("R5 set beats clear", {7'b0, kbd_irq}, 8'h01);
    cpu_port_wr = 1; cpu_port_wdata = 3'b101; cyc(); idle(); #1;
    chk("R8 mask kbd", {7'b0, kbd_irq}, 8'h00);

    // random phases: enable-flags clear, then set, then after reset
    do_reset();
    rand_cycles(3000, 0);
    rand_cycles(3000, 1);
    cpu_en_flags = 1; cyc(); idle();
    rand_cycles(3000, 0);
    do_reset();
    rand_cycles(2000, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule